// File: doc/BRIEF.md
# GPIO bank with per-pin interrupt detection

A bank of general-purpose pins, up to sixteen, each of which software can turn into an output or leave as an input. Software drives the output pins through a data word and reads the pin levels back through another word. A 32-bit register bus with a single write strobe and a combinational read path reaches all of the configuration.

Every input is brought into the clock domain by a two-stage synchronizer. A per-pin detector then looks for a rising edge, a falling edge, either edge, a high level or a low level, depending on a 3-bit mode field. A hit on an enabled pin sets a sticky status bit, and software clears it by writing a one. A mask, set and cleared through two separate write-one words, decides which status bits reach the single interrupt request output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all enable and status bits are 0, every implemented pin is masked (the mask reads all ones), every pin is an input (pin_oe_o = 0), every mode field is 0, the output data is 0 and irq_o is 0.
- R2: A write to word 8 sets the direction bits. A 1 makes the pin an output, and pin_oe_o follows the word. Bits at or above NUM_PINS read back as 0.
- R3: Word 6 holds the output data and drives pin_o directly. Word 7 reads the synchronized pin levels, which show a change to pin_i after the second rising edge and not after the first.
- R4: Each pin's 3-bit mode field sits at bit 4*p of word 9 for pins 0 to 7, and at bit 4*(p-8) of word 10 for pins 8 to 15. Bits outside the implemented fields read as 0.
- R5: Mode codes: 1 detects a rising edge, 0 a falling edge, 4 either edge, 3 a high level and 2 a low level. Codes 5, 6 and 7 detect nothing.
- R6: Word 0 is the per-pin enable. A status bit (read at word 1) can become set only while its enable bit is 1.
- R7: Writing word 3 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. In the cycle of the clear, the clear takes priority over a new detection, so a level that is still active sets the bit again one cycle later.
- R8: Writing a 1 to a bit of word 4 masks that pin, and writing a 1 to a bit of word 5 unmasks it. Data bits that are 0 leave the mask unchanged. Word 4 reads the mask and word 5 reads 0.
- R9: irq_o is the OR over all pins of status AND NOT mask, and word 2 reads that same status AND NOT mask vector.
- R10: A pin_i change that matches the pin's mode sets its status bit on the third rising edge after the change. irq_o is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, captured on the rising edge |
| bus_addr_i | input | ADDR_W | Word index of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| pin_i | input | NUM_PINS | Pin levels, asynchronous |
| pin_o | output | NUM_PINS | Output data |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Detection is exercised with a table that pairs each mode code with a starting pin level and a final pin level, on pins in both mode words. The pairs show whether the detector reacts to the right edge direction rather than to any change, and a level-mode row that clears the status while the level is still active separates a sticky level from one that re-arms. Directed sequences hold the enable low while a pin moves, use an undefined mode code, and write clear and mask words with zero bits or with foreign bits set. Each of these shows whether the write or the stimulus acts only on the bits it names.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_IEN   = 0;
  localparam int WORD_STAT  = 1;
  localparam int WORD_DISP  = 2;
  localparam int WORD_CLR   = 3;
  localparam int WORD_MSET  = 4;
  localparam int WORD_MCLR  = 5;
  localparam int WORD_DOUT  = 6;
  localparam int WORD_DIN   = 7;
  localparam int WORD_DIR   = 8;
  localparam int WORD_MODE0 = 9;
  localparam int WORD_MODE1 = 10;
  localparam int WORD_COUNT = 12;

  localparam int MODE_W        = 3;
  localparam int MODE_STRIDE   = 4;
  localparam int PINS_PER_WORD = 8;

  typedef enum logic [MODE_W-1:0] {
    MODE_FALL = 3'd0,
    MODE_RISE = 3'd1,
    MODE_LOW  = 3'd2,
    MODE_HIGH = 3'd3,
    MODE_BOTH = 3'd4
  } irq_mode_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PINS-1:0]              lvl_i,
  input  logic [NUM_PINS-1:0][MODE_W-1:0]  mode_i,
  output logic [NUM_PINS-1:0]              det_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      case (mode_i[p])
        MODE_FALL: det_o[p] = prev_q[p] & ~lvl_i[p];
        MODE_RISE: det_o[p] = ~prev_q[p] & lvl_i[p];
        MODE_LOW:  det_o[p] = ~lvl_i[p];
        MODE_HIGH: det_o[p] = lvl_i[p];
        MODE_BOTH: det_o[p] = prev_q[p] ^ lvl_i[p];
        default:   det_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [NUM_PINS-1:0]              det_i,
  input  logic [NUM_PINS-1:0]              lvl_i,
  output logic [NUM_PINS-1:0]              en_o,
  output logic [NUM_PINS-1:0]              status_o,
  output logic [NUM_PINS-1:0]              mask_o,
  output logic [NUM_PINS-1:0]              dout_o,
  output logic [NUM_PINS-1:0]              dir_o,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  mode_o
);
  logic [WORD_COUNT-1:0] wsel;
  logic [NUM_PINS-1:0]   wbits, clr_bits, status_d;
  logic [NUM_PINS-1:0]   en_q, status_q, mask_q, dout_q, dir_q;
  logic [MODE_W-1:0]     mode_q [NUM_PINS];
  logic [DATA_W-1:0]     mode_w0, mode_w1;
  logic                  unused_wdata;

  assign wbits        = wdata_i[NUM_PINS-1:0];
  assign unused_wdata = ^wdata_i;

  always_comb
    for (int i = 0; i < WORD_COUNT; i++)
      wsel[i] = we_i && (addr_i == ADDR_W'(i));

  // clear wins over a same-cycle hit; an active level re-sets next cycle
  assign clr_bits = wsel[WORD_CLR] ? wbits : '0;
  assign status_d = (status_q | (det_i & en_q)) & ~clr_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      status_q <= '0;
      mask_q   <= '1;
      dout_q   <= '0;
      dir_q    <= '0;
    end else begin
      status_q <= status_d;
      if (wsel[WORD_IEN])  en_q   <= wbits;
      if (wsel[WORD_MSET]) mask_q <= mask_q | wbits;
      if (wsel[WORD_MCLR]) mask_q <= mask_q & ~wbits;
      if (wsel[WORD_DOUT]) dout_q <= wbits;
      if (wsel[WORD_DIR])  dir_q  <= wbits;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    localparam int BANK = p / PINS_PER_WORD;
    localparam int SLOT = p % PINS_PER_WORD;
    localparam int SEL  = (BANK == 0) ? WORD_MODE0 : WORD_MODE1;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)        mode_q[p] <= MODE_FALL;
      else if (wsel[SEL]) mode_q[p] <= wdata_i[SLOT*MODE_STRIDE +: MODE_W];

    assign mode_o[p] = mode_q[p];
  end

  always_comb begin
    mode_w0 = '0;
    mode_w1 = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (p < PINS_PER_WORD)
        mode_w0[(p % PINS_PER_WORD)*MODE_STRIDE +: MODE_W] = mode_q[p];
      else
        mode_w1[(p % PINS_PER_WORD)*MODE_STRIDE +: MODE_W] = mode_q[p];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(WORD_IEN):   rdata_o = DATA_W'(en_q);
      ADDR_W'(WORD_STAT):  rdata_o = DATA_W'(status_q);
      ADDR_W'(WORD_DISP):  rdata_o = DATA_W'(status_q & ~mask_q);
      ADDR_W'(WORD_MSET):  rdata_o = DATA_W'(mask_q);
      ADDR_W'(WORD_DOUT):  rdata_o = DATA_W'(dout_q);
      ADDR_W'(WORD_DIN):   rdata_o = DATA_W'(lvl_i);
      ADDR_W'(WORD_DIR):   rdata_o = DATA_W'(dir_q);
      ADDR_W'(WORD_MODE0): rdata_o = mode_w0;
      ADDR_W'(WORD_MODE1): rdata_o = mode_w1;
      default:             rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign dout_o   = dout_q;
  assign dir_o    = dir_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]             lvl, det;
  logic [NUM_PINS-1:0]             en_q, status_q, mask_q, dout_q, dir_q;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (lvl)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .mode_i (mode),
    .det_o  (det)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .det_i    (det),
    .lvl_i    (lvl),
    .en_o     (en_q),
    .status_o (status_q),
    .mask_o   (mask_q),
    .dout_o   (dout_q),
    .dir_o    (dir_q),
    .mode_o   (mode)
  );

  assign pin_o    = dout_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] status_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] en_i
);
  logic [NUM_PINS-1:0] wbits;
  assign wbits = bus_wdata_i[NUM_PINS-1:0];

  // R7
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(WORD_CLR)) |=> ((status_i & $past(wbits)) == '0));

  // R6
  set_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(en_i)) == '0));

  // R8
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(WORD_MSET)) |=> ((mask_i & $past(wbits)) == $past(wbits)));

  // R8
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(WORD_MCLR)) |=> ((mask_i & $past(wbits)) == '0));

  // R9
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1) |-> !irq_o);

  // R9
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .status_i    (status_q),
  .mask_i      (mask_q),
  .en_i        (en_q)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int NP = 12;
  localparam logic [3:0] A_IEN = 0, A_STAT = 1, A_DISP = 2, A_CLR = 3, A_MSET = 4,
                         A_MCLR = 5, A_DOUT = 6, A_DIN = 7, A_DIR = 8, A_M0 = 9, A_M1 = 10;

  typedef struct packed {
    logic [3:0] pin;
    logic [2:0] mode;
    logic       init;
    logic       fin;
    logic       do_clr;
    logic       exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  3'd0, 1'b1, 1'b0, 1'b0, 1'b1},  // falling, falls
    '{4'd9,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0},  // falling, rises
    '{4'd3,  3'd1, 1'b0, 1'b1, 1'b0, 1'b1},  // rising, rises
    '{4'd11, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // rising, falls
    '{4'd0,  3'd4, 1'b0, 1'b1, 1'b0, 1'b1},  // both, rises
    '{4'd9,  3'd4, 1'b1, 1'b0, 1'b0, 1'b1},  // both, falls
    '{4'd3,  3'd2, 1'b1, 1'b0, 1'b1, 1'b1},  // low level held through clear
    '{4'd8,  3'd2, 1'b0, 1'b1, 1'b1, 1'b0},  // low level gone before clear
    '{4'd11, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1},  // high level held
    '{4'd0,  3'd3, 1'b1, 1'b0, 1'b1, 1'b0},  // high level gone
    '{4'd7,  3'd6, 1'b0, 1'b1, 1'b0, 1'b0},  // undefined code
    '{4'd10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}   // falling, no change
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pout, poe;
  logic          irq;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) u_gpio_irq_bank (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pin_i       (pins),
    .pin_o       (pout),
    .pin_oe_o    (poe),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_MSET, r); check("R1 mask", r, 32'hFFF);
    bus_rd(A_DIR,  r); check("R1 dir", r, 0);
    bus_rd(A_STAT, r); check("R1 status", r, 0);
    bus_rd(A_IEN,  r); check("R1 enable", r, 0);
    bus_rd(A_M0,   r); check("R1 mode0", r, 0);
    bus_rd(A_DOUT, r); check("R1 dout", r, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 oe", 32'(poe), 0);

    // R2 direction
    bus_wr(A_DIR, 32'hFFFF_FFFF);
    bus_rd(A_DIR, r); check("R2 dir upper zero", r, 32'h0000_0FFF);
    check("R2 oe all", 32'(poe), 32'hFFF);
    bus_wr(A_DIR, 32'h0A5);
    check("R2 oe pattern", 32'(poe), 32'h0A5);

    // R3 output and input paths
    bus_wr(A_DOUT, 32'h5A3);
    check("R3 pin_o", 32'(pout), 32'h5A3);
    @(negedge clk);
    addr = A_DIN; pins = 12'h3C1;
    @(negedge clk); #1 check("R3 din after one edge", rdata, 0);
    @(negedge clk); #1 check("R3 din after two edges", rdata, 32'h3C1);
    pins = '0;
    repeat (3) @(negedge clk);

    // R4 mode field packing
    bus_wr(A_M0, 32'hFFFF_FFFF);
    bus_rd(A_M0, r); check("R4 mode0 fields", r, 32'h7777_7777);
    bus_wr(A_M1, 32'hFFFF_FFFF);
    bus_rd(A_M1, r); check("R4 mode1 fields", r, 32'h0000_7777);
    bus_wr(A_M0, 32'h0000_0020);
    bus_rd(A_M0, r); check("R4 mode0 pin1 slot", r, 32'h0000_0020);
    bus_wr(A_M0, 0);
    bus_wr(A_M1, 0);

    // R8 mask set and clear
    bus_wr(A_MCLR, 32'h005);
    bus_rd(A_MSET, r); check("R8 mask clear", r, 32'hFFA);
    bus_wr(A_MSET, 0);
    bus_rd(A_MSET, r); check("R8 set zero bits", r, 32'hFFA);
    bus_wr(A_MCLR, 0);
    bus_rd(A_MSET, r); check("R8 clear zero bits", r, 32'hFFA);
    bus_wr(A_MSET, 32'h001);
    bus_rd(A_MSET, r); check("R8 mask set", r, 32'hFFB);
    bus_rd(A_MCLR, r); check("R8 word5 reads zero", r, 0);
    bus_wr(A_MSET, 32'hFFF);

    // R10 latency, pin 5 rising
    bus_wr(A_M0, 32'h1 << 20);
    bus_wr(A_IEN, 32'h020);
    bus_wr(A_MCLR, 32'h020);
    pins[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 check("R10 irq after two edges", 32'(irq), 0);
    @(negedge clk); #1 check("R10 irq after three edges", 32'(irq), 1);

    // R9 display and gating
    bus_rd(A_DISP, r); check("R9 display", r, 32'h020);
    bus_wr(A_MSET, 32'h020);
    check("R9 masked irq", 32'(irq), 0);
    bus_rd(A_DISP, r); check("R9 masked display", r, 0);
    bus_rd(A_STAT, r); check("R9 status kept under mask", r, 32'h020);

    // R7 clear
    bus_wr(A_CLR, 0);
    bus_rd(A_STAT, r); check("R7 zero clear", r, 32'h020);
    bus_wr(A_CLR, 32'h010);
    bus_rd(A_STAT, r); check("R7 foreign clear", r, 32'h020);
    bus_wr(A_CLR, 32'h020);
    bus_rd(A_STAT, r); check("R7 clear bit", r, 0);

    // R6 enable gating
    bus_wr(A_IEN, 0);
    bus_rd(A_IEN, r); check("R6 enable readback", r, 0);
    pins[5] = 1'b0;
    repeat (4) @(negedge clk);
    pins[5] = 1'b1;
    repeat (5) @(negedge clk);
    bus_rd(A_STAT, r); check("R6 disabled pin", r, 0);

    // R5 undefined code with level held high
    bus_wr(A_M0, 32'h5 << 20);
    bus_wr(A_IEN, 32'h020);
    repeat (4) @(negedge clk);
    bus_rd(A_STAT, r); check("R5 code 5 inert", r, 0);
    bus_wr(A_M0, 32'h7 << 20);
    repeat (4) @(negedge clk);
    bus_rd(A_STAT, r); check("R5 code 7 inert", r, 0);
    bus_wr(A_IEN, 0);
    bus_wr(A_MSET, 32'hFFF);
    pins = '0;

    // R5 / R7 mode table
    for (int i = 0; i < NVEC; i++) begin
      vec_t        v;
      logic [31:0] bit_v;
      v = VECS[i];
      bit_v = 32'd1 << v.pin;
      bus_wr(A_IEN, 0);
      bus_wr(v.pin < 8 ? A_M0 : A_M1, 32'(v.mode) << (4 * (v.pin % 8)));
      bus_wr(A_MCLR, bit_v);
      pins[v.pin] = v.init;
      repeat (4) @(negedge clk);
      bus_wr(A_CLR, 32'hFFF);
      bus_wr(A_IEN, bit_v);
      pins[v.pin] = v.fin;
      repeat (4) @(negedge clk);
      if (v.do_clr) begin
        bus_wr(A_CLR, bit_v);
        @(negedge clk);
      end
      bus_rd(A_STAT, r);
      check($sformatf("R5 vector %0d status", i), (r >> v.pin) & 32'd1, 32'(v.exp));
      check($sformatf("R7 R9 vector %0d irq", i), 32'(irq), 32'(v.exp));
      bus_wr(A_MSET, 32'hFFF);
      pins = '0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule